// File: doc/BRIEF.md
# Call/Return Context Stack

This unit keeps the processor context across subroutine calls, forced aborts and returns. For every instruction it accepts, it takes a control code together with the target PC, the return PC, the current user-mode and traps-enabled bits and the current local-frame base. One cycle later it reports the PC to continue from, the mode bits and frame base that apply from then on, and a flush request for the prefetch buffer. It also reports a trap request when a return finds the stack empty, and an error pulse when a push or a return falls outside the stack's envelope.

Calls and aborts push a frame. The frame holds the return PC and a packed status word: a version field, the user-mode bit, the traps-enabled bit and the frame base. Returns pop the youngest frame and restore it. The frames sit in a circular buffer of `DEPTH` entries. A soft level `SOFT_MAX`, below `DEPTH`, makes a return from a deep stack fault, but only when the frame it would pop has traps enabled.

When calls and returns come close together, the control stack needs time to settle. The unit therefore reports a stall count and holds `busy` high for that many cycles. It accepts no instruction while `busy` is high.

Top module: `ctx_stack_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid`, `flush`, `trap_req`, `stack_err`, `busy`, `stall_cnt`, `next_pc`, `nx_user`, `nx_traps`, `nx_lbase` and `nx_ver` are all zero, and the stack is empty.
- R2: Control code 0 (next), code 1 (switch) and the unused codes 5 to 7 give `next_pc` = `tgt_pc`. The mode bits and frame base pass through, `nx_ver` = `VERSION`, and the stack does not change.
- R3: Code 2 (call) pushes {return PC `ret_pc`, version `VERSION`, `cur_user`, `cur_traps`, `cur_lbase`}. It gives `next_pc` = `tgt_pc`, and the mode bits pass through.
- R4: Code 3 (abort) pushes the same frame as a call, taken from the state before the abort. It then reports `nx_user` = 0 and `nx_traps` = 0.
- R5: When code 4 (return) finds a non-empty stack and no soft fault applies, it reports the youngest frame's PC, user bit, traps bit, frame base and version on the outputs, and it removes that frame.
- R6: A return on an empty stack gives `next_pc` = `TRAP_VEC` and `trap_req` = 1. The mode bits pass through unchanged and nothing is popped.
- R7: A return with more than `SOFT_MAX` entries stacked, whose youngest frame has traps enabled, raises `stack_err`, pops nothing and gives `next_pc` = `tgt_pc`. The same return whose youngest frame has traps disabled proceeds as in R5.
- R8: A call or abort on a stack that already holds `DEPTH` entries raises `stack_err` and leaves the entry count unchanged. Its frame replaces the youngest frame.
- R9: `flush` pulses for switch, call, abort and return. It stays low for next and for codes 5 to 7.
- R10: Frames come back in last-in first-out order even after the circular youngest-entry pointer has wrapped past the end of storage.
- R11: Call, abort and return are the interlocked codes. When one of them follows the previous interlocked code at a distance d of 1 or 2 accepted instructions, `stall_cnt` = 3 − d and `busy` stays high for that many cycles. A larger distance, or no earlier interlocked code since reset, gives a stall of 0.
- R12: An instruction presented while `busy` is high is ignored. It produces no `out_valid` and leaves the stack unchanged.
- R13: Every output of an accepted instruction appears in the cycle after acceptance, qualified by a single-cycle `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| ctl | input | 3 | Control code: 0 next, 1 switch, 2 call, 3 abort, 4 return |
| tgt_pc | input | PC_W | New PC for sequential flow, calls and aborts |
| ret_pc | input | PC_W | Return PC pushed by call/abort |
| cur_user | input | 1 | Current user-mode bit |
| cur_traps | input | 1 | Current traps-enabled bit |
| cur_lbase | input | LB_W | Current local-frame base index |
| out_valid | output | 1 | Results of an accepted instruction are valid |
| next_pc | output | PC_W | PC to continue from |
| nx_user | output | 1 | User-mode bit from now on |
| nx_traps | output | 1 | Traps-enabled bit from now on |
| nx_lbase | output | LB_W | Frame base from now on |
| nx_ver | output | VER_W | Version field of the restored frame, else `VERSION` |
| flush | output | 1 | Prefetch buffer flush request |
| trap_req | output | 1 | Stack underflow trap taken |
| stack_err | output | 1 | Push beyond capacity or soft-level return fault |
| stall_cnt | output | $clog2(SPAN+1) | Interlock stall cycles for the accepted instruction |
| busy | output | 1 | Interlock stall in progress; input ignored |

## Verification
A wrong entry count or a misplaced youngest pointer does not show at once. It surfaces at the next return that reaches the damaged frame, as a wrong `next_pc` or wrong mode bits, or as a trap or error pulse where none belongs. The bench therefore always follows pushes with returns that unwind through the pointer wrap and past the overflow-overwritten frame. A corrupted interlock history shows within one instruction, as a wrong `stall_cnt` or a `busy` window of the wrong length. An input that is wrongly accepted during `busy` shows as a stray `out_valid`, and later as an extra frame that a return pops.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;

   // control codes presented with each instruction
   localparam logic [2:0] CTL_NEXT   = 3'd0;
   localparam logic [2:0] CTL_SWITCH = 3'd1;
   localparam logic [2:0] CTL_CALL   = 3'd2;
   localparam logic [2:0] CTL_ABORT  = 3'd3;
   localparam logic [2:0] CTL_RETURN = 3'd4;

   function automatic logic is_push_code(input logic [2:0] c);
      return (c == CTL_CALL) || (c == CTL_ABORT);
   endfunction

   function automatic logic is_flush_code(input logic [2:0] c);
      return (c == CTL_SWITCH) || (c == CTL_CALL) || (c == CTL_ABORT) || (c == CTL_RETURN);
   endfunction

endpackage

// File: rtl/ctx_stack_store.sv
module ctx_stack_store #(
   parameter int DEPTH = 16,
   parameter int ENT_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        push,
   input  logic                        pop,
   input  logic [ENT_W-1:0]            wr_ent,
   output logic [ENT_W-1:0]            top_ent,
   output logic [$clog2(DEPTH+1)-1:0]  level,
   output logic                        full,
   output logic                        empty
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("ctx_stack_store: DEPTH must be at least 2");
   end

   logic [ENT_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0] ptr;
   logic [PTR_W-1:0] ptr_up;
   logic [PTR_W-1:0] ptr_dn;

   // circular youngest pointer: free wrap for powers of two, explicit otherwise
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign ptr_up = ptr + 1'b1;
      assign ptr_dn = ptr - 1'b1;
   end else begin : g_mod
      assign ptr_up = (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
      assign ptr_dn = (ptr == '0) ? PTR_W'(DEPTH - 1) : ptr - 1'b1;
   end

   assign full    = (level == CNT_W'(DEPTH));
   assign empty   = (level == '0);
   assign top_ent = mem[ptr];

   always_ff @(posedge clk) begin
      if (push) begin
         if (full) mem[ptr]    <= wr_ent;
         else      mem[ptr_up] <= wr_ent;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr   <= '0;
         level <= '0;
      end else if (push && !full) begin
         ptr   <= ptr_up;
         level <= level + 1'b1;
      end else if (pop && !empty) begin
         ptr   <= ptr_dn;
         level <= level - 1'b1;
      end
   end

   assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CNT_W'(DEPTH));
   assert_full_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |=> (level == $past(level)));
   assert_pop_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !empty) |=> (level + 1'b1 == $past(level)));
   assert_push_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !full) |=> (level == $past(level) + 1'b1));
   assert_excl_ops_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && pop));

endmodule

// File: rtl/ctx_interlock.sv
module ctx_interlock #(
   parameter int SPAN = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       accept,
   input  logic                       is_cr,
   output logic [$clog2(SPAN+1)-1:0]  stall_now,
   output logic                       busy
);
   localparam int GW = $clog2(SPAN + 1);

   if (SPAN < 1) begin : g_bad_span
      $error("ctx_interlock: SPAN must be at least 1");
   end

   // instructions accepted since the last interlocked one, saturating at SPAN
   logic [GW-1:0] gap;
   logic [GW-1:0] hold;

   assign stall_now = (is_cr && (gap < GW'(SPAN))) ? (GW'(SPAN) - gap) : '0;
   assign busy      = (hold != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap  <= GW'(SPAN);
         hold <= '0;
      end else if (accept) begin
         if (is_cr)                 gap <= GW'(1);
         else if (gap < GW'(SPAN))  gap <= gap + 1'b1;
         hold <= stall_now;
      end else if (hold != '0) begin
         hold <= hold - 1'b1;
      end
   end

   assert_hold_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      hold < GW'(SPAN));
   assert_busy_drains_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (hold + 1'b1 == $past(hold)));
   assert_no_accept_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !accept);

endmodule

// File: rtl/ctx_stack_unit.sv
module ctx_stack_unit
   import ctx_stack_pkg::*;
#(
   parameter int              PC_W     = 32,
   parameter int              LB_W     = 5,
   parameter int              VER_W    = 3,
   parameter logic [VER_W-1:0] VERSION = 1,
   parameter int              DEPTH    = 16,
   parameter int              SOFT_MAX = 12,
   parameter int              SPAN     = 3,
   parameter logic [PC_W-1:0] TRAP_VEC = 'h40
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic [2:0]                 ctl,
   input  logic [PC_W-1:0]            tgt_pc,
   input  logic [PC_W-1:0]            ret_pc,
   input  logic                       cur_user,
   input  logic                       cur_traps,
   input  logic [LB_W-1:0]            cur_lbase,
   output logic                       out_valid,
   output logic [PC_W-1:0]            next_pc,
   output logic                       nx_user,
   output logic                       nx_traps,
   output logic [LB_W-1:0]            nx_lbase,
   output logic [VER_W-1:0]           nx_ver,
   output logic                       flush,
   output logic                       trap_req,
   output logic                       stack_err,
   output logic [$clog2(SPAN+1)-1:0]  stall_cnt,
   output logic                       busy
);
   localparam int ENT_W = PC_W + VER_W + LB_W + 2;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int SW    = $clog2(SPAN + 1);

   if (SOFT_MAX < 1 || SOFT_MAX >= DEPTH) begin : g_bad_soft
      $error("ctx_stack_unit: SOFT_MAX must lie in 1..DEPTH-1");
   end
   if (PC_W < 2 || LB_W < 1 || VER_W < 1) begin : g_bad_width
      $error("ctx_stack_unit: field widths too small");
   end

   // frame layout: {pc, version, user, traps, lbase}
   logic [ENT_W-1:0]  wr_ent, top_ent;
   logic [PC_W-1:0]   t_pc;
   logic [VER_W-1:0]  t_ver;
   logic              t_user, t_traps;
   logic [LB_W-1:0]   t_lbase;
   logic [CNT_W-1:0]  level;
   logic              full, empty;
   logic              accept, do_push, do_ret, ret_soft, do_pop, is_cr;
   logic [SW-1:0]     stall_now;

   assign wr_ent = {ret_pc, VERSION, cur_user, cur_traps, cur_lbase};
   assign {t_pc, t_ver, t_user, t_traps, t_lbase} = top_ent;

   assign accept   = in_valid && !busy;
   assign do_push  = accept && is_push_code(ctl);
   assign do_ret   = accept && (ctl == CTL_RETURN);
   assign ret_soft = do_ret && !empty && (level > CNT_W'(SOFT_MAX)) && t_traps;
   assign do_pop   = do_ret && !empty && !ret_soft;
   assign is_cr    = do_push || do_ret;

   ctx_stack_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (do_push),
      .pop     (do_pop),
      .wr_ent  (wr_ent),
      .top_ent (top_ent),
      .level   (level),
      .full    (full),
      .empty   (empty)
   );

   ctx_interlock #(.SPAN(SPAN)) u_ilock (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .is_cr     (is_cr),
      .stall_now (stall_now),
      .busy      (busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         next_pc   <= '0;
         nx_user   <= 1'b0;
         nx_traps  <= 1'b0;
         nx_lbase  <= '0;
         nx_ver    <= '0;
         flush     <= 1'b0;
         trap_req  <= 1'b0;
         stack_err <= 1'b0;
         stall_cnt <= '0;
      end else begin
         out_valid <= accept;
         flush     <= 1'b0;
         trap_req  <= 1'b0;
         stack_err <= 1'b0;
         if (accept) begin
            stall_cnt <= stall_now;
            flush     <= is_flush_code(ctl);
            next_pc   <= tgt_pc;
            nx_user   <= cur_user;
            nx_traps  <= cur_traps;
            nx_lbase  <= cur_lbase;
            nx_ver    <= VERSION;
            if (do_push) begin
               stack_err <= full;
               if (ctl == CTL_ABORT) begin
                  nx_user  <= 1'b0;
                  nx_traps <= 1'b0;
               end
            end else if (do_ret) begin
               if (empty) begin
                  next_pc  <= TRAP_VEC;
                  trap_req <= 1'b1;
               end else if (ret_soft) begin
                  stack_err <= 1'b1;
               end else begin
                  next_pc  <= t_pc;
                  nx_user  <= t_user;
                  nx_traps <= t_traps;
                  nx_lbase <= t_lbase;
                  nx_ver   <= t_ver;
               end
            end
         end
      end
   end

   assert_abort_kernel_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && ctl == CTL_ABORT) |=> (!nx_user && !nx_traps && out_valid));
   assert_underflow_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && ctl == CTL_RETURN && empty) |=> (trap_req && next_pc == TRAP_VEC && empty));
   assert_soft_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ret_soft |=> (stack_err && level == $past(level)));
   assert_next_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && ctl == CTL_NEXT) |=> (!flush && !trap_req && !stack_err));
   assert_flush_codes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && ctl != CTL_NEXT && ctl <= CTL_RETURN) |=> flush);
   assert_single_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid));
   assert_pulses_qualified_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (flush || trap_req || stack_err) |-> out_valid);

endmodule

// File: tb/ctx_stack_unit_tb.sv
`timescale 1ns/1ps
module ctx_stack_unit_tb;
   localparam int              PC_W  = 16;
   localparam int              LB_W  = 4;
   localparam int              VER_W = 2;
   localparam logic [1:0]      VER   = 2'd2;
   localparam int              DEPTH = 5;
   localparam int              SOFT  = 3;
   localparam int              SPAN  = 3;
   localparam logic [15:0]     TRAP  = 16'h0040;

   logic clk = 0, rst_n = 0, in_valid = 0;
   logic [2:0] ctl = 0;
   logic [15:0] tgt_pc = 0, ret_pc = 0;
   logic cur_user = 0, cur_traps = 0;
   logic [3:0] cur_lbase = 0;
   logic out_valid, nx_user, nx_traps, flush, trap_req, stack_err, busy;
   logic [15:0] next_pc;
   logic [3:0] nx_lbase;
   logic [1:0] nx_ver, stall_cnt;

   int checks = 0, errors = 0;
   bit done = 0;

   // bench model of the stack
   logic [15:0] m_pc [0:DEPTH-1];
   logic        m_u  [0:DEPTH-1];
   logic        m_t  [0:DEPTH-1];
   logic [3:0]  m_lb [0:DEPTH-1];
   int m_cnt = 0, m_gap = SPAN;
   logic [15:0] lfsr = 16'hACE1;

   always #10 clk = ~clk;

   ctx_stack_unit #(.PC_W(PC_W), .LB_W(LB_W), .VER_W(VER_W), .VERSION(VER),
      .DEPTH(DEPTH), .SOFT_MAX(SOFT), .SPAN(SPAN), .TRAP_VEC(TRAP)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ctl(ctl), .tgt_pc(tgt_pc),
      .ret_pc(ret_pc), .cur_user(cur_user), .cur_traps(cur_traps), .cur_lbase(cur_lbase),
      .out_valid(out_valid), .next_pc(next_pc), .nx_user(nx_user), .nx_traps(nx_traps),
      .nx_lbase(nx_lbase), .nx_ver(nx_ver), .flush(flush), .trap_req(trap_req),
      .stack_err(stack_err), .stall_cnt(stall_cnt), .busy(busy));

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; in_valid = 0;
      repeat (2) @(negedge clk);
      chk(!out_valid && !flush && !trap_req && !stack_err && !busy, "R1", "pulses in reset",
          {out_valid, flush, trap_req, stack_err, busy}, 0);
      chk(next_pc == 0 && nx_lbase == 0 && nx_ver == 0 && !nx_user && !nx_traps && stall_cnt == 0,
          "R1", "state in reset", next_pc, 0);
      rst_n = 1;
      m_cnt = 0; m_gap = SPAN;
      @(negedge clk);
      chk(!out_valid && !busy && next_pc == 0, "R1", "after reset", {out_valid, busy}, 0);
   endtask

   task automatic issue(input logic [2:0] c, input logic [15:0] tg, input logic [15:0] rt,
                        input logic u, input logic t, input logic [3:0] lb, input bit poke);
      logic [15:0] e_pc; logic e_u, e_t, e_fl, e_tr, e_er; logic [3:0] e_lb; logic [1:0] e_v;
      int e_st, idx; bit cr; string req;
      e_pc = tg; e_u = u; e_t = t; e_lb = lb; e_v = VER; e_tr = 0; e_er = 0;
      e_fl = (c >= 3'd1 && c <= 3'd4);
      cr = (c >= 3'd2 && c <= 3'd4);
      req = "R2";
      e_st = (cr && m_gap < SPAN) ? SPAN - m_gap : 0;
      if (cr) m_gap = 1; else if (m_gap < SPAN) m_gap++;
      if (c == 3'd2 || c == 3'd3) begin
         req = (c == 3'd2) ? "R3" : "R4";
         if (m_cnt == DEPTH) begin e_er = 1; idx = m_cnt - 1; req = "R8"; end
         else begin idx = m_cnt; m_cnt++; end
         m_pc[idx] = rt; m_u[idx] = u; m_t[idx] = t; m_lb[idx] = lb;
         if (c == 3'd3) begin e_u = 0; e_t = 0; end
      end else if (c == 3'd4) begin
         if (m_cnt == 0) begin e_pc = TRAP; e_tr = 1; req = "R6"; end
         else if (m_cnt > SOFT && m_t[m_cnt-1]) begin e_er = 1; req = "R7"; end
         else begin
            req = (m_cnt > SOFT) ? "R7" : "R5";
            m_cnt--;
            e_pc = m_pc[m_cnt]; e_u = m_u[m_cnt]; e_t = m_t[m_cnt];
            e_lb = m_lb[m_cnt]; e_v = VER;
         end
      end
      @(negedge clk);
      in_valid = 1; ctl = c; tgt_pc = tg; ret_pc = rt; cur_user = u; cur_traps = t; cur_lbase = lb;
      @(negedge clk);
      in_valid = 0;
      chk(out_valid, "R13", "out_valid", out_valid, 1);
      chk(next_pc == e_pc, req, "next_pc", next_pc, e_pc);
      chk({nx_user, nx_traps} == {e_u, e_t}, req, "mode bits", {nx_user, nx_traps}, {e_u, e_t});
      chk(nx_lbase == e_lb && nx_ver == e_v, req, "lbase/ver", {nx_lbase, nx_ver}, {e_lb, e_v});
      chk(trap_req == e_tr, (e_tr ? "R6" : req), "trap_req", trap_req, e_tr);
      chk(stack_err == e_er, req, "stack_err", stack_err, e_er);
      chk(flush == e_fl, "R9", "flush", flush, e_fl);
      chk(stall_cnt == 2'(e_st), "R11", "stall_cnt", stall_cnt, e_st);
      for (int k = 0; k < e_st; k++) begin
         chk(busy, "R11", "busy window", busy, 1);
         if (k > 0) chk(!out_valid, (poke ? "R12" : "R11"), "no output while busy", out_valid, 0);
         in_valid = poke; ctl = 3'd2; tgt_pc = 16'hDEAD; ret_pc = 16'hBAD0; cur_traps = 1;
         @(negedge clk);
      end
      in_valid = 0;
      chk(!busy, "R11", "busy released", busy, 0);
      if (e_st > 0) chk(!out_valid, (poke ? "R12" : "R11"), "last busy cycle", out_valid, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      do_reset();                                         // R1
      // R2, R9: sequential codes and unused codes
      issue(3'd0, 16'h0100, 16'h0, 1, 0, 4'h3, 0);
      issue(3'd1, 16'h0200, 16'h0, 0, 1, 4'h5, 0);
      issue(3'd5, 16'h0300, 16'h0, 1, 1, 4'h7, 0);
      issue(3'd6, 16'h0304, 16'h0, 0, 0, 4'h1, 0);
      issue(3'd7, 16'h0308, 16'h0, 1, 0, 4'h2, 0);
      // R6: return on empty, first interlocked code has no stall
      issue(3'd4, 16'h0400, 16'h0, 1, 1, 4'h9, 0);
      // R3, R11: calls at distances 1, 2, 3
      issue(3'd2, 16'h1000, 16'h2000, 0, 0, 4'h0, 0);     // d=1 -> 2
      issue(3'd0, 16'h1004, 16'h0, 0, 0, 4'h0, 0);
      issue(3'd2, 16'h1100, 16'h2100, 1, 0, 4'h1, 0);     // d=2 -> 1
      issue(3'd0, 16'h1104, 16'h0, 0, 0, 4'h0, 0);
      issue(3'd0, 16'h1108, 16'h0, 0, 0, 4'h0, 0);
      issue(3'd2, 16'h1200, 16'h2200, 0, 0, 4'h2, 0);     // d=3 -> 0
      issue(3'd2, 16'h1300, 16'h2300, 1, 1, 4'h3, 0);     // count 4, traps set
      // R7: soft fault above SOFT with traps set
      issue(3'd4, 16'h1400, 16'h0, 0, 0, 4'h4, 0);
      // R8: fill, then overflow overwrites youngest
      issue(3'd2, 16'h1500, 16'h2500, 0, 0, 4'h5, 0);
      issue(3'd2, 16'h1600, 16'h2600, 1, 0, 4'h6, 0);
      issue(3'd4, 16'h1700, 16'h0, 0, 0, 4'h0, 0);        // pops overwritten frame (R8, R7 no fault)
      issue(3'd4, 16'h1800, 16'h0, 0, 0, 4'h0, 0);        // traps set again -> fault
      do_reset();
      // R4, R5: abort forces kernel, return restores
      issue(3'd3, 16'h3000, 16'h3100, 1, 1, 4'hA, 0);
      issue(3'd4, 16'h3200, 16'h0, 0, 0, 4'h0, 0);
      // R10: pointer wraps with frames outstanding
      for (int r = 0; r < 4; r++) begin
         issue(3'd2, 16'h4000 + 16'(r), 16'h5000 + 16'(r * 2), r[0], 0, 4'(r), 0);
         issue(3'd3, 16'h4100 + 16'(r), 16'h5001 + 16'(r * 2), r[1], 0, 4'(r + 8), 0);
         issue(3'd4, 16'h4200, 16'h0, 0, 0, 4'h0, 0);
      end
      for (int r = 0; r < 5; r++) issue(3'd4, 16'h4300, 16'h0, 0, 0, 4'h0, 0);
      // R12: inputs offered during busy are ignored
      issue(3'd2, 16'h6000, 16'h6100, 0, 0, 4'h1, 0);
      issue(3'd2, 16'h6200, 16'h6300, 1, 0, 4'h2, 1);
      issue(3'd4, 16'h6400, 16'h0, 0, 0, 4'h0, 0);
      issue(3'd4, 16'h6500, 16'h0, 0, 0, 4'h0, 0);
      issue(3'd4, 16'h6600, 16'h0, 0, 0, 4'h0, 0);        // empty: proves no stray push
      // mixed sweep
      for (int n = 0; n < 200; n++) begin
         logic [2:0] c;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         case (lfsr[1:0])
            2'd0: c = 3'd4;
            2'd1: c = 3'd2;
            2'd2: c = lfsr[2] ? 3'd3 : 3'd4;
            default: c = lfsr[3] ? 3'd0 : 3'd1;
         endcase
         issue(c, lfsr ^ 16'h5A5A, {lfsr[7:0], lfsr[15:8]}, lfsr[4], lfsr[5] & lfsr[6], lfsr[11:8], lfsr[9]);
         if (n % 50 == 49) do_reset();
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule